// File: doc/BRIEF.md
# Call-with-Register-Save Sequencer

This block carries out a subroutine call that also spills part of the register file to the stack. A decoder passes in the fields of the five-byte instruction: a 16-bit PC-relative displacement, a register-list byte and an 8-bit frame adjustment. The current program counter and stack pointer come in alongside these fields. The sequencer first writes the return address (PC + 5) to the word at SP. It then writes each selected register one word lower than the previous store, with one 32-bit store accepted per handshake on a simple write port.

After the last store is accepted, the block sets three outputs in the same cycle. The new stack pointer is SP minus the zero-extended adjustment. The link value is the return address. The branch target is PC plus the sign-extended displacement. A one-cycle completion pulse marks that cycle. The surrounding pipeline holds the call request until the sequencer is idle, and it picks up the three results on the completion pulse.

Top module: `callsave_seq`

## Requirements
- R1: Out of reset, `busy`, `st_valid` and `done` are 0, and `sp_out`, `link_out` and `pc_out` are 0.
- R2: The first store of every call is at address `sp_in`, and its data is `pc_in + 5`. Both values are taken when the call is accepted.
- R3: Each later store is at an address 4 lower than the previous store, modulo 2^32. Saved registers are written in the fixed order slot0, slot1, slot2, slot3, and only selected slots are written, with no gaps between them.
- R4: Register-list bit 7 selects slot0 (D2), bit 6 selects slot1 (D3), bit 5 selects slot2 (A2) and bit 4 selects slot3 (A3). Slot i is `save_regs_in[32*i+31:32*i]`. Bits 3..0 of the list have no effect.
- R5: A call makes exactly 1 + (number of set bits in list bits 7..4) stores. A store completes in a cycle where `st_valid` and `st_ready` are both 1.
- R6: While `st_valid` is 1 and `st_ready` is 0, `st_valid`, `st_addr` and `st_data` stay unchanged into the next cycle.
- R7: In the cycle after the last store completes, `done` is 1 for exactly one cycle. In that same cycle `sp_out = sp - zext(adj)`, `link_out = pc + 5` and `pc_out = pc + sext(disp)`, all modulo 2^32.
- R8: A call is accepted only when `busy` is 0. While busy, `call_req` and every call input, including the register values, have no effect on the stores or the results of the call in progress.
- R9: `sp_out`, `link_out` and `pc_out` change only in a cycle where `done` is 1.
- R10: An accepted call raises `busy` in the next cycle. `busy` is 0 again in the cycle where `done` is 1, so a new call can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Call request; accepted when `busy` is 0 |
| pc_in | input | 32 | Address of the call instruction |
| sp_in | input | 32 | Stack pointer before the call |
| disp_in | input | 16 | Signed PC-relative displacement |
| rlist_in | input | 8 | Register-list byte (bits 7..4 used) |
| adj_in | input | 8 | Unsigned frame adjustment |
| save_regs_in | input | 128 | Four saveable register values, slot0 in the low word |
| busy | output | 1 | A call is in progress |
| st_valid | output | 1 | A store is offered on the write port |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |
| st_ready | input | 1 | Memory accepts the offered store |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Updated stack pointer |
| link_out | output | 32 | Return address for the link register |
| pc_out | output | 32 | Branch target |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, four saveable slots, a 16-bit displacement and an 8-bit adjustment. With only four slots, the bench can run all 16 combinations of the used list bits against three acceptance patterns on `st_ready`. These patterns are always ready, two stalls before each accept, and alternating. Each combination also uses a different low nibble, so every store count and packing order is seen with and without back-pressure. Extra cases place SP near zero so that store addresses and the new SP wrap. Other cases use a negative displacement and a full adjustment byte, and some change every call input while a call is busy.

// File: rtl/callsave_pkg.sv
// Package: callsave_pkg
// Shared constants and the control state type for the call-with-save
// sequencer. Assumes byte addressing and 32-bit word stores.
package callsave_pkg;

    // Length of the call instruction in bytes; the return address is PC plus this.
    localparam int INSTR_BYTES = 5;

    // Byte distance between consecutive stack stores.
    localparam int WORD_BYTES = 4;

    // Control states of the sequencer.
    typedef enum logic {
        CS_IDLE  = 1'b0,
        CS_STORE = 1'b1
    } cs_state_t;

endpackage

// File: rtl/callsave_pick.sv
// Module: callsave_pick
// Picks the lowest-numbered pending save slot and returns the mask with
// that slot cleared. The lowest index is the first register stored.
// Assumes: purely combinational; when no bit is pending, idx is 0 and
// rest is all zero.
module callsave_pick #(
    parameter int NSAVE = 4,
    parameter int IDX_W = 2
) (
    input  logic [NSAVE-1:0] pend,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [NSAVE-1:0] rest
);

    // Priority search from slot 0 upward, then clear the chosen slot.
    always_comb begin
        logic found;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NSAVE; i++) begin
            if (pend[i] && !found) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
        any  = found;
        rest = pend;
        if (found) begin
            rest[idx] = 1'b0;
        end
    end

endmodule

// File: rtl/callsave_agen.sv
// Module: callsave_agen
// Store address generator. Loads the starting stack pointer when a call is
// accepted and steps down by one word after each store that has a follower.
// Assumes: load and step are never asserted in the same cycle.
module callsave_agen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] addr_q;

    // Address register: reset, load at acceptance, decrement per store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (step) begin
            addr_q <= addr_q - STEP_V;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/callsave_result.sv
// Module: callsave_result
// Computes and registers the three architectural results of the call:
// the new stack pointer, the link value and the branch target. It raises
// a one-cycle done flag in the same cycle the results appear.
// Assumes: the operands are stable in the cycle commit is asserted.
module callsave_result #(
    parameter int AW     = 32,
    parameter int DISP_W = 16,
    parameter int ADJ_W  = 8,
    parameter int RET_OFS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [AW-1:0]     pc_base,
    input  logic [AW-1:0]     sp_base,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADJ_W-1:0]  adj,
    output logic              done,
    output logic [AW-1:0]     sp_out,
    output logic [AW-1:0]     link_out,
    output logic [AW-1:0]     pc_out
);

    localparam logic [AW-1:0] RET_V = AW'(RET_OFS);

    logic [AW-1:0] disp_sx;
    logic [AW-1:0] adj_zx;
    logic [AW-1:0] sp_nx;
    logic [AW-1:0] link_nx;
    logic [AW-1:0] pc_nx;

    // Extend the displacement with its sign and the adjustment with zeros.
    always_comb begin
        disp_sx = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
        adj_zx  = {{(AW-ADJ_W){1'b0}}, adj};
        sp_nx   = sp_base - adj_zx;
        link_nx = pc_base + RET_V;
        pc_nx   = pc_base + disp_sx;
    end

    // Result registers: hold their values until the next commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_out   <= '0;
            link_out <= '0;
            pc_out   <= '0;
        end else if (commit) begin
            sp_out   <= sp_nx;
            link_out <= link_nx;
            pc_out   <= pc_nx;
        end
    end

    // Completion flag: high for exactly the cycle after commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= commit;
        end
    end

endmodule

// File: rtl/callsave_seq.sv
// Module: callsave_seq (top)
// Sequencer for a call that also saves registers. When a call is accepted
// it takes a snapshot of the call fields and the saveable registers. It
// then offers one store at a time: the return address at SP, then each
// selected register one word lower. After the last store is accepted it
// commits SP, link and PC together with a one-cycle done pulse.
// Assumes: list bit (LIST_W-1-i) selects slot i; the lower list bits are
// unused. The requester holds call_req until busy is low.
module callsave_seq
    import callsave_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NSAVE  = 4,
    parameter int DISP_W = 16,
    parameter int ADJ_W  = 8,
    parameter int LIST_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_req,
    input  logic [AW-1:0]       pc_in,
    input  logic [AW-1:0]       sp_in,
    input  logic [DISP_W-1:0]   disp_in,
    input  logic [LIST_W-1:0]   rlist_in,
    input  logic [ADJ_W-1:0]    adj_in,
    input  logic [NSAVE*AW-1:0] save_regs_in,
    output logic                busy,
    output logic                st_valid,
    output logic [AW-1:0]       st_addr,
    output logic [AW-1:0]       st_data,
    input  logic                st_ready,
    output logic                done,
    output logic [AW-1:0]       sp_out,
    output logic [AW-1:0]       link_out,
    output logic [AW-1:0]       pc_out
);

    localparam int IDX_W = (NSAVE > 1) ? $clog2(NSAVE) : 1;
    localparam logic [AW-1:0] RET_V = AW'(INSTR_BYTES);

    cs_state_t         state_q;
    logic [NSAVE-1:0]  sel_mask;
    logic [NSAVE-1:0]  pend_q;
    logic [NSAVE-1:0]  pend_rest;
    logic              pend_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [AW-1:0]     snap_q [NSAVE];
    logic [AW-1:0]     data_q;
    logic [AW-1:0]     pc_q;
    logic [AW-1:0]     sp_q;
    logic [DISP_W-1:0] disp_q;
    logic [ADJ_W-1:0]  adj_q;
    logic              accept;
    logic              hs;
    logic              step;
    logic              last;

    // Map the list byte to slot selects: the top bit is slot 0.
    for (genvar gi = 0; gi < NSAVE; gi++) begin : g_sel
        assign sel_mask[gi] = rlist_in[LIST_W-1-gi];
    end

    // Handshake and sequencing conditions.
    always_comb begin
        accept = call_req && (state_q == CS_IDLE);
        hs     = (state_q == CS_STORE) && st_ready;
        step   = hs && pend_any;
        last   = hs && !pend_any;
    end

    // Control state: idle until accepted, store until the last handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else if (accept) begin
            state_q <= CS_STORE;
        end else if (last) begin
            state_q <= CS_IDLE;
        end
    end

    // Pending slot mask: loaded at acceptance, one slot retired per store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= sel_mask;
        end else if (step) begin
            pend_q <= pend_rest;
        end
    end

    // Register snapshot, one word per slot, taken at acceptance.
    for (genvar gs = 0; gs < NSAVE; gs++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q[gs] <= '0;
            end else if (accept) begin
                snap_q[gs] <= save_regs_in[gs*AW +: AW];
            end
        end
    end

    // Call field capture for the result stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            sp_q   <= '0;
            disp_q <= '0;
            adj_q  <= '0;
        end else if (accept) begin
            pc_q   <= pc_in;
            sp_q   <= sp_in;
            disp_q <= disp_in;
            adj_q  <= adj_in;
        end
    end

    // Store data: return address first, then the next selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= pc_in + RET_V;
        end else if (step) begin
            data_q <= snap_q[pick_idx];
        end
    end

    callsave_pick #(
        .NSAVE (NSAVE),
        .IDX_W (IDX_W)
    ) u_pick (
        .pend (pend_q),
        .any  (pend_any),
        .idx  (pick_idx),
        .rest (pend_rest)
    );

    callsave_agen #(
        .AW   (AW),
        .STEP (WORD_BYTES)
    ) u_agen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .base  (sp_in),
        .step  (step),
        .addr  (st_addr)
    );

    callsave_result #(
        .AW      (AW),
        .DISP_W  (DISP_W),
        .ADJ_W   (ADJ_W),
        .RET_OFS (INSTR_BYTES)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (last),
        .pc_base  (pc_q),
        .sp_base  (sp_q),
        .disp     (disp_q),
        .adj      (adj_q),
        .done     (done),
        .sp_out   (sp_out),
        .link_out (link_out),
        .pc_out   (pc_out)
    );

    assign busy     = (state_q != CS_IDLE);
    assign st_valid = (state_q == CS_STORE);
    assign st_data  = data_q;

endmodule

// File: rtl/callsave_chk.sv
// Module: callsave_chk
// Assertion checker bound to callsave_seq. It watches only the ports and
// keeps its own copy of the accepted call and its own store counter.
module callsave_chk #(
    parameter int AW     = 32,
    parameter int NSAVE  = 4,
    parameter int DISP_W = 16,
    parameter int ADJ_W  = 8,
    parameter int LIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_req,
    input logic              busy,
    input logic [AW-1:0]     pc_in,
    input logic [AW-1:0]     sp_in,
    input logic [DISP_W-1:0] disp_in,
    input logic [LIST_W-1:0] rlist_in,
    input logic [ADJ_W-1:0]  adj_in,
    input logic              st_valid,
    input logic [AW-1:0]     st_addr,
    input logic [AW-1:0]     st_data,
    input logic              st_ready,
    input logic              done,
    input logic [AW-1:0]     sp_out,
    input logic [AW-1:0]     link_out,
    input logic [AW-1:0]     pc_out
);

    localparam logic [LIST_W-1:0] USED_BITS = {{NSAVE{1'b1}}, {(LIST_W-NSAVE){1'b0}}};

    logic [AW-1:0]     lat_pc;
    logic [AW-1:0]     lat_sp;
    logic [DISP_W-1:0] lat_disp;
    logic [ADJ_W-1:0]  lat_adj;
    logic [LIST_W-1:0] lat_list;
    logic [7:0]        hs_cnt;
    logic              acc;

    assign acc = call_req && !busy;

    // Shadow copy of the accepted call and a count of completed stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_pc <= '0; lat_sp <= '0; lat_disp <= '0; lat_adj <= '0;
            lat_list <= '0; hs_cnt <= '0;
        end else if (acc) begin
            lat_pc <= pc_in; lat_sp <= sp_in; lat_disp <= disp_in;
            lat_adj <= adj_in; lat_list <= rlist_in; hs_cnt <= '0;
        end else if (st_valid && st_ready) begin
            hs_cnt <= hs_cnt + 8'd1;
        end
    end

    a_r1_no_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_valid);

    a_r2_first_store: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> st_valid && st_addr == $past(sp_in) && st_data == $past(pc_in) + AW'(5));

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_valid && st_ready) && st_valid |-> st_addr == $past(st_addr) - AW'(4));

    a_r5_store_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hs_cnt == 8'(1 + $countones(lat_list & USED_BITS)));

    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_addr) && $stable(st_data));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_valid && st_ready));

    a_r7_results: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sp_out == lat_sp - {{(AW-ADJ_W){1'b0}}, lat_adj}
              && link_out == lat_pc + AW'(5)
              && pc_out == lat_pc + {{(AW-DISP_W){lat_disp[DISP_W-1]}}, lat_disp});

    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(sp_out) && $stable(link_out) && $stable(pc_out));

    a_r10_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind callsave_seq callsave_chk #(
    .AW     (AW),
    .NSAVE  (NSAVE),
    .DISP_W (DISP_W),
    .ADJ_W  (ADJ_W),
    .LIST_W (LIST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .busy     (busy),
    .pc_in    (pc_in),
    .sp_in    (sp_in),
    .disp_in  (disp_in),
    .rlist_in (rlist_in),
    .adj_in   (adj_in),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .st_ready (st_ready),
    .done     (done),
    .sp_out   (sp_out),
    .link_out (link_out),
    .pc_out   (pc_out)
);

// File: tb/callsave_seq_test.sv
// Bench for callsave_seq: sweeps every used list pattern under three
// store-acceptance patterns, plus wrap and busy-injection cases.
module callsave_seq_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         call_req;
    logic [31:0]  pc_in, sp_in;
    logic [15:0]  disp_in;
    logic [7:0]   rlist_in, adj_in;
    logic [127:0] save_regs_in;
    logic         busy, st_valid, st_ready, done;
    logic [31:0]  st_addr, st_data, sp_out, link_out, pc_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    callsave_seq uut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .pc_in(pc_in),
        .sp_in(sp_in), .disp_in(disp_in), .rlist_in(rlist_in), .adj_in(adj_in),
        .save_regs_in(save_regs_in), .busy(busy), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready), .done(done),
        .sp_out(sp_out), .link_out(link_out), .pc_out(pc_out)
    );

    // Compare and count one check.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one call and verify stores and results against arithmetic expectations.
    task automatic do_call(input logic [31:0] pc, input logic [31:0] sp, input logic [15:0] d,
                           input logic [7:0] lst, input logic [7:0] a, input int mode,
                           input bit inject);
        logic [31:0] ea [5];
        logic [31:0] ed [5];
        logic [31:0] ra [8];
        logic [31:0] rd [8];
        logic [31:0] regs [4];
        logic [31:0] sa, sd;
        int ne, nrec;
        bit stalled, fin, rdy;
        for (int i = 0; i < 4; i++) regs[i] = pc ^ (32'h0101_0101 * (i + 1)) ^ 32'hA5A5_0000;
        ne = 1; ea[0] = sp; ed[0] = pc + 32'd5;
        for (int i = 0; i < 4; i++) begin
            if (lst[7-i]) begin
                ea[ne] = sp - 32'(4 * ne);
                ed[ne] = regs[i];
                ne++;
            end
        end
        @(negedge clk);
        call_req = 1'b1; pc_in = pc; sp_in = sp; disp_in = d; rlist_in = lst; adj_in = a;
        save_regs_in = {regs[3], regs[2], regs[1], regs[0]};
        check("R10 idle before accept", 32'(busy), 32'd0);
        @(negedge clk);
        call_req = 1'b0;
        check("R10 busy after accept", 32'(busy), 32'd1);
        nrec = 0; stalled = 1'b0; fin = 1'b0; sa = '0; sd = '0;
        for (int c = 0; c < 60 && !fin; c++) begin
            call_req = 1'b0;
            if (done) begin
                fin = 1'b1;
            end else begin
                if (stalled) begin
                    check("R6 valid held", 32'(st_valid), 32'd1);
                    check("R6 addr held", st_addr, sa);
                    check("R6 data held", st_data, sd);
                end
                if (inject && c == 1) begin
                    call_req = 1'b1; pc_in = ~pc; sp_in = ~sp; disp_in = ~d;
                    rlist_in = ~lst; adj_in = ~a; save_regs_in = ~save_regs_in;
                end
                rdy = (mode == 0) ? 1'b1 : (mode == 1) ? (c % 3 == 2) : c[0];
                st_ready = rdy;
                if (st_valid && rdy && nrec < 8) begin
                    ra[nrec] = st_addr; rd[nrec] = st_data; nrec++;
                end
                stalled = st_valid && !rdy; sa = st_addr; sd = st_data;
                @(negedge clk);
            end
        end
        check("R7 done seen", 32'(fin), 32'd1);
        check("R5 store count", 32'(nrec), 32'(ne));
        for (int k = 0; k < ne && k < nrec; k++) begin
            check(k == 0 ? "R2 first addr" : "R3 R4 store addr", ra[k], ea[k]);
            check(k == 0 ? "R2 first data" : "R3 R4 R8 store data", rd[k], ed[k]);
        end
        check("R7 sp_out", sp_out, sp - {24'd0, a});
        check("R7 link_out", link_out, pc + 32'd5);
        check("R7 pc_out", pc_out, pc + {{16{d[15]}}, d});
        check("R10 idle on done", 32'(busy), 32'd0);
        st_ready = 1'b0;
        @(negedge clk);
        check("R7 done one cycle", 32'(done), 32'd0);
        check("R9 sp held", sp_out, sp - {24'd0, a});
        check("R9 pc held", pc_out, pc + {{16{d[15]}}, d});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; call_req = 1'b0; st_ready = 1'b0;
        pc_in = '0; sp_in = '0; disp_in = '0; rlist_in = '0; adj_in = '0; save_regs_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 st_valid", 32'(st_valid), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 sp_out", sp_out, 32'd0);
        check("R1 link_out", link_out, 32'd0);
        check("R1 pc_out", pc_out, 32'd0);
        // Sweep used list bits under each ready pattern; low nibble varies (R4).
        for (int m = 0; m < 3; m++) begin
            for (int u = 0; u < 16; u++) begin
                do_call(32'h0040_1000 + 32'(u * 64 + m * 4096),
                        32'h2000_0100 - 32'(u * 32),
                        16'(u * 300 + m * 7),
                        {4'(u), 4'(u ^ (m * 5 + 3))},
                        8'(u * 11 + m),
                        m, m == 1);
            end
        end
        // Address wrap, negative displacement, full adjustment (R3, R7).
        do_call(32'h0000_0010, 32'h0000_0008, 16'h8000, 8'hF0, 8'hFF, 0, 1'b0);
        do_call(32'hFFFF_FFFE, 32'h0000_0004, 16'hFFF0, 8'hA5, 8'h10, 2, 1'b1);
        // Back-to-back calls with no saved registers and the low nibble set (R4, R10).
        do_call(32'h1234_5678, 32'h8000_0000, 16'h0004, 8'h0F, 8'h00, 0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule